// File: doc/BRIEF.md
# Multi-Pipe Packet Receive Handler

This block is the control path at the receiving end of a packet radio. A front-end hands it packets that have already been demodulated and CRC-checked: a byte stream with a header (destination address, CRC-good flag, no-acknowledge bit) that is valid on the first beat. The handler compares the address against up to six logical pipes. Each pipe has its own address, enable, auto-acknowledge enable and static payload width. Each accepted payload goes out on a byte-wide write port toward an RX FIFO, tagged with the pipe it arrived on. Packets that are rejected are drained and discarded.

A small queue of pipe tags follows the FIFO's entry order. The host always sees which pipe the oldest stored payload came from, and removes that entry with a pop pulse. Every stored payload raises a sticky data-ready flag, which drives the interrupt line. After a payload is stored, the block can raise an acknowledgement request toward the transmit side. The request says whether a queued transmit payload should ride on that acknowledgement.

Reception is gated. Chip enable together with receive mode starts a settling timer of 130 µs, counted in clock cycles. Packets are ignored until the timer expires. Both streaming interfaces are valid/ready. The packet input only moves when the handler is draining a rejected packet, or when the write port accepts the byte it is forwarding. The acknowledgement request is held until the transmit side takes it. No new packet is taken while a request is held.

Top module: `pipe_rx_handler`

## Requirements
- R1: While `chip_en` and `rx_mode` are both 1, reception opens after SETTLE = 130·CLK_KHZ/1000 cycles and `rx_active` then reads 1. A packet whose first beat is offered before that is consumed from the input and discarded: no write and no acknowledgement.
- R2: Pipe i (0..NP-1) matches a packet when all of these hold: `cfg_pipe_en[i]`=1, its width field `cfg_width[i*WW +: WW]` is nonzero, `cfg_addr[i*AW +: AW]` equals `pk_addr`, and `pk_crc_ok`=1. A packet that matches no pipe is drained and discarded.
- R3: When several pipes match, the lowest-numbered one receives the packet.
- R4: An accepted packet's first min(length, width) bytes appear in order on the write port with `fifo_wr_pipe` set to the pipe number. `fifo_wr_last` is 1 on the final forwarded byte. Bytes beyond the pipe width are consumed and dropped.
- R5: The data-ready flag is set in the cycle after the final payload byte is written. `irq` is 1 exactly while the flag is set. A one on `rx_dr_clr` clears the flag. If a clear and a new store fall in the same cycle, the flag stays set.
- R6: `rx_pipe_no` shows the pipe of the oldest stored payload, or 7 when none is stored. `rx_pop` removes the oldest entry, and has no effect when the store is empty.
- R7: With SLOTS payloads stored, `rx_full` is 1. A packet arriving in that state is discarded with no write and no acknowledgement.
- R8: After the last input beat of an accepted packet whose pipe has `cfg_auto_ack` set and whose `pk_no_ack` is 0, `ack_valid` rises. It carries `ack_pipe` and `ack_has_pld`, which is `tx_pending` sampled at that last beat. Both stay stable until `ack_ready`. `pk_ready` is 0 meanwhile.
- R9: When `chip_en` drops, `rx_active` falls in the same cycle and new packets are discarded. Stored entries, `rx_pipe_no` and the data-ready flag are unaffected and remain poppable.
- R10: While `fifo_wr_valid` is 1 and `fifo_wr_ready` is 0, `pk_ready` is 0 and no input byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip enable |
| rx_mode | input | 1 | 1 selects receive role |
| cfg_pipe_en | input | NP | Per-pipe enable |
| cfg_auto_ack | input | NP | Per-pipe auto-acknowledge enable |
| cfg_addr | input | NP*AW | Pipe addresses, pipe i at bits i*AW +: AW |
| cfg_width | input | NP*WW | Static payload widths, pipe i at bits i*WW +: WW |
| pk_valid | input | 1 | Packet byte valid |
| pk_ready | output | 1 | Packet byte accepted |
| pk_data | input | 8 | Payload byte |
| pk_last | input | 1 | Final byte of packet |
| pk_addr | input | AW | Packet address, valid on first beat |
| pk_crc_ok | input | 1 | CRC good, valid on first beat |
| pk_no_ack | input | 1 | Sender requests no acknowledgement, valid on first beat |
| fifo_wr_valid | output | 1 | Write byte valid |
| fifo_wr_ready | input | 1 | FIFO accepts byte |
| fifo_wr_data | output | 8 | Write byte |
| fifo_wr_last | output | 1 | Final byte of stored payload |
| fifo_wr_pipe | output | 3 | Pipe tag of payload |
| rx_pop | input | 1 | Remove oldest stored entry |
| rx_pipe_no | output | 3 | Pipe of oldest entry, 7 if empty |
| rx_full | output | 1 | Store holds SLOTS entries |
| rx_dr_clr | input | 1 | Write-one clear of data-ready flag |
| irq | output | 1 | Interrupt, follows data-ready flag |
| tx_pending | input | 1 | A transmit payload is queued for acknowledgement |
| ack_valid | output | 1 | Acknowledgement request valid |
| ack_ready | input | 1 | Acknowledgement request taken |
| ack_pipe | output | 3 | Pipe to acknowledge |
| ack_has_pld | output | 1 | Acknowledgement carries the queued payload |
| rx_active | output | 1 | Settling done, receiving |

## Verification
Two kinds of event can land in the same cycle. The first pair is a host clear of the data-ready flag and the storing of a new payload. The bench provokes this by holding `rx_dr_clr` high for the whole of a packet. It then requires `irq` to be 1 afterwards, and requires a later lone clear to drop it. The second pair is a pending acknowledgement and the arrival of the next packet. Here `ack_ready` is held low while another packet's first beat is offered. The bench judges that `pk_ready` stays 0 and `ack_valid` holds until the request is taken.

// File: rtl/pipe_rx_pkg.sv
package pipe_rx_pkg;
  localparam int PIPE_IDW = 3;
  localparam logic [PIPE_IDW-1:0] PIPE_NONE = 3'd7;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PASS = 2'd1,
    S_DROP = 2'd2,
    S_ACK  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/pipe_rx_settle.sv
module pipe_rx_settle #(
  parameter int SETTLE_CYC = 2080
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic listen
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!enable)                  cnt <= '0;
    else if (cnt != CW'(SETTLE_CYC))   cnt <= cnt + CW'(1);
  end

  assign listen = enable && (cnt == CW'(SETTLE_CYC));

  // the receiver stays deaf in the cycle after enable has been low
  p_deaf_after_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !listen || $rose(enable) == 1'b0 && !listen);
endmodule

// File: rtl/pipe_rx_match.sv
module pipe_rx_match
  import pipe_rx_pkg::*;
#(
  parameter int NP = 6,
  parameter int AW = 40,
  parameter int WW = 6
) (
  input  logic [AW-1:0]       addr,
  input  logic                crc_ok,
  input  logic [NP-1:0]       pipe_en,
  input  logic [NP-1:0]       pipe_aa,
  input  logic [NP*AW-1:0]    pipe_addr,
  input  logic [NP*WW-1:0]    pipe_width,
  output logic                hit,
  output logic [PIPE_IDW-1:0] pipe,
  output logic [WW-1:0]       width,
  output logic                aa
);
  logic [NP-1:0] cand;
  logic [NP-1:0] grant;

  for (genvar g = 0; g < NP; g++) begin : g_cmp
    assign cand[g] = crc_ok && pipe_en[g]
                  && (pipe_width[g*WW +: WW] != '0)
                  && (pipe_addr[g*AW +: AW] == addr);
  end

  // isolate lowest set bit independently of the encoder below
  assign grant = cand & (~cand + NP'(1));

  always_comb begin
    hit   = |cand;
    pipe  = PIPE_NONE;
    width = '0;
    aa    = 1'b0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pipe  = PIPE_IDW'(i);
        width = pipe_width[i*WW +: WW];
        aa    = pipe_aa[i];
      end
    end
  end

  always_comb begin
    if (hit) begin
      p_lowest_wins_r3: assert (grant == (NP'(1) << pipe));
    end
  end
endmodule

// File: rtl/pipe_rx_tagq.sv
module pipe_rx_tagq
  import pipe_rx_pkg::*;
#(
  parameter int SLOTS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [PIPE_IDW-1:0] push_pipe,
  input  logic                pop,
  output logic [PIPE_IDW-1:0] head,
  output logic                full
);
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CW = $clog2(SLOTS + 1);

  logic [PIPE_IDW-1:0] mem [SLOTS];
  logic [PW-1:0]       rd_ptr, wr_ptr;
  logic [CW-1:0]       cnt;
  logic                empty, do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(SLOTS - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(SLOTS));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? PIPE_NONE : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= push_pipe;
        wr_ptr      <= step(wr_ptr);
      end
      if (do_pop) rd_ptr <= step(rd_ptr);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_pop_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (head == PIPE_NONE));
endmodule

// File: rtl/pipe_rx_handler.sv
module pipe_rx_handler
  import pipe_rx_pkg::*;
#(
  parameter int NP      = 6,
  parameter int AW      = 40,
  parameter int WW      = 6,
  parameter int SLOTS   = 3,
  parameter int CLK_KHZ = 16000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chip_en,
  input  logic                rx_mode,
  input  logic [NP-1:0]       cfg_pipe_en,
  input  logic [NP-1:0]       cfg_auto_ack,
  input  logic [NP*AW-1:0]    cfg_addr,
  input  logic [NP*WW-1:0]    cfg_width,
  input  logic                pk_valid,
  output logic                pk_ready,
  input  logic [7:0]          pk_data,
  input  logic                pk_last,
  input  logic [AW-1:0]       pk_addr,
  input  logic                pk_crc_ok,
  input  logic                pk_no_ack,
  output logic                fifo_wr_valid,
  input  logic                fifo_wr_ready,
  output logic [7:0]          fifo_wr_data,
  output logic                fifo_wr_last,
  output logic [PIPE_IDW-1:0] fifo_wr_pipe,
  input  logic                rx_pop,
  output logic [PIPE_IDW-1:0] rx_pipe_no,
  output logic                rx_full,
  input  logic                rx_dr_clr,
  output logic                irq,
  input  logic                tx_pending,
  output logic                ack_valid,
  input  logic                ack_ready,
  output logic [PIPE_IDW-1:0] ack_pipe,
  output logic                ack_has_pld,
  output logic                rx_active
);
  localparam int SETTLE_CYC = (130 * CLK_KHZ) / 1000;

  rx_state_t           st;
  logic                listen;
  logic                dec_hit, dec_aa;
  logic [PIPE_IDW-1:0] dec_pipe;
  logic [WW-1:0]       dec_width;
  logic [PIPE_IDW-1:0] cur_pipe;
  logic [WW-1:0]       cur_w, idx;
  logic                cur_ack;
  logic                dr_flag;
  logic                in_win, pk_hs, commit;

  pipe_rx_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (chip_en && rx_mode),
    .listen (listen)
  );

  pipe_rx_match #(.NP(NP), .AW(AW), .WW(WW)) u_match (
    .addr       (pk_addr),
    .crc_ok     (pk_crc_ok),
    .pipe_en    (cfg_pipe_en),
    .pipe_aa    (cfg_auto_ack),
    .pipe_addr  (cfg_addr),
    .pipe_width (cfg_width),
    .hit        (dec_hit),
    .pipe       (dec_pipe),
    .width      (dec_width),
    .aa         (dec_aa)
  );

  pipe_rx_tagq #(.SLOTS(SLOTS)) u_tagq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (commit),
    .push_pipe (cur_pipe),
    .pop       (rx_pop),
    .head      (rx_pipe_no),
    .full      (rx_full)
  );

  assign rx_active = listen;
  assign in_win    = (idx < cur_w);

  always_comb begin
    unique case (st)
      S_PASS:  pk_ready = in_win ? fifo_wr_ready : 1'b1;
      S_DROP:  pk_ready = 1'b1;
      default: pk_ready = 1'b0;
    endcase
  end

  assign pk_hs         = pk_valid && pk_ready;
  assign fifo_wr_valid = (st == S_PASS) && in_win && pk_valid;
  assign fifo_wr_data  = pk_data;
  assign fifo_wr_last  = pk_last || (idx == cur_w - WW'(1));
  assign fifo_wr_pipe  = cur_pipe;
  assign commit        = fifo_wr_valid && fifo_wr_ready && fifo_wr_last;
  assign ack_valid     = (st == S_ACK);
  assign irq           = dr_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cur_pipe    <= '0;
      cur_w       <= '0;
      cur_ack     <= 1'b0;
      idx         <= '0;
      ack_pipe    <= '0;
      ack_has_pld <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (pk_valid) begin
          if (listen && dec_hit && !rx_full) begin
            st       <= S_PASS;
            cur_pipe <= dec_pipe;
            cur_w    <= dec_width;
            cur_ack  <= dec_aa && !pk_no_ack;
            idx      <= '0;
          end else begin
            st <= S_DROP;
          end
        end
        S_PASS: if (pk_hs) begin
          if (idx != '1) idx <= idx + WW'(1);
          if (pk_last) begin
            st          <= cur_ack ? S_ACK : S_IDLE;
            ack_pipe    <= cur_pipe;
            ack_has_pld <= tx_pending;
          end
        end
        S_DROP: if (pk_hs && pk_last) st <= S_IDLE;
        S_ACK:  if (ack_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dr_flag <= 1'b0;
    else if (commit)    dr_flag <= 1'b1;
    else if (rx_dr_clr) dr_flag <= 1'b0;
  end

  p_settle_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && pk_valid && !listen) |=> (st == S_DROP));
  p_dr_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> irq);
  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_pipe) && $stable(ack_has_pld)));
  p_ack_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> !pk_ready);
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_valid && !fifo_wr_ready) |-> !pk_ready);
endmodule

// File: tb/tb_pipe_rx_handler.sv
module tb_pipe_rx_handler;
  localparam int NP = 6, AW = 40, WW = 6, SLOTS = 3, CLK_KHZ = 100;
  localparam int SETTLE = (130 * CLK_KHZ) / 1000;

  typedef struct packed {
    logic [39:0] addr; logic crc; logic nak; logic [7:0] len; logic txp;
    logic [7:0] n; logic [2:0] pipe; logic ack;
  } vec_t;

  localparam logic [39:0] A0 = 40'hA5C39E1000, A1 = 40'hA5C39E1001,
                          A2 = 40'hA5C39E1002, A3 = 40'hA5C39E1003,
                          A4 = 40'hA5C39E1004;

  localparam vec_t VECS [10] = '{
    '{A0, 1'b1, 1'b0, 8'd4, 1'b0, 8'd4, 3'd0, 1'b1},   // R2 R4 R8 plain pipe 0
    '{A1, 1'b1, 1'b0, 8'd8, 1'b1, 8'd8, 3'd1, 1'b1},   // R8 queued payload rides along
    '{A2, 1'b1, 1'b0, 8'd3, 1'b0, 8'd3, 3'd2, 1'b1},   // R3 pipes 2 and 5 share address
    '{A1, 1'b0, 1'b0, 8'd8, 1'b0, 8'd0, 3'd7, 1'b0},   // R2 bad CRC
    '{A3, 1'b1, 1'b0, 8'd2, 1'b0, 8'd0, 3'd7, 1'b0},   // R2 disabled pipe
    '{A4, 1'b1, 1'b0, 8'd5, 1'b0, 8'd5, 3'd4, 1'b0},   // R8 auto-ack off
    '{A1, 1'b1, 1'b1, 8'd8, 1'b0, 8'd8, 3'd1, 1'b0},   // R8 no-ack bit
    '{A0, 1'b1, 1'b0, 8'd7, 1'b0, 8'd4, 3'd0, 1'b1},   // R4 truncated to width
    '{40'h1, 1'b1, 1'b0, 8'd3, 1'b0, 8'd0, 3'd7, 1'b0}, // R2 unknown address
    '{A1, 1'b1, 1'b0, 8'd3, 1'b0, 8'd3, 3'd1, 1'b1}    // R4 shorter than width
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic chip_en = 0, rx_mode = 0;
  logic [NP-1:0] cfg_pipe_en, cfg_auto_ack;
  logic [NP*AW-1:0] cfg_addr;
  logic [NP*WW-1:0] cfg_width;
  logic pk_valid = 0, pk_ready, pk_last = 0, pk_crc_ok = 0, pk_no_ack = 0;
  logic [7:0] pk_data = 0;
  logic [AW-1:0] pk_addr = 0;
  logic fifo_wr_valid, fifo_wr_ready = 1, fifo_wr_last;
  logic [7:0] fifo_wr_data;
  logic [2:0] fifo_wr_pipe, rx_pipe_no, ack_pipe;
  logic rx_pop = 0, rx_full, rx_dr_clr = 0, irq, tx_pending = 0;
  logic ack_valid, ack_ready = 1, ack_has_pld, rx_active;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pipe_rx_handler #(.NP(NP), .AW(AW), .WW(WW), .SLOTS(SLOTS), .CLK_KHZ(CLK_KHZ)) dut (
    .clk, .rst_n, .chip_en, .rx_mode, .cfg_pipe_en, .cfg_auto_ack, .cfg_addr, .cfg_width,
    .pk_valid, .pk_ready, .pk_data, .pk_last, .pk_addr, .pk_crc_ok, .pk_no_ack,
    .fifo_wr_valid, .fifo_wr_ready, .fifo_wr_data, .fifo_wr_last, .fifo_wr_pipe,
    .rx_pop, .rx_pipe_no, .rx_full, .rx_dr_clr, .irq, .tx_pending,
    .ack_valid, .ack_ready, .ack_pipe, .ack_has_pld, .rx_active);

  // monitor of both output streams
  int mon_wr = 0, mon_lastcnt = 0, mon_ack = 0;
  logic [7:0] mon_data [64];
  logic [2:0] mon_pipe = 0, mon_ack_pipe = 0;
  logic mon_lastflag = 0, mon_ack_pld = 0;
  always @(posedge clk) begin
    if (fifo_wr_valid && fifo_wr_ready) begin
      mon_data[mon_wr % 64] <= fifo_wr_data;
      mon_wr <= mon_wr + 1;
      mon_pipe <= fifo_wr_pipe;
      mon_lastflag <= fifo_wr_last;
      if (fifo_wr_last) mon_lastcnt <= mon_lastcnt + 1;
    end
    if (ack_valid && ack_ready) begin
      mon_ack <= mon_ack + 1;
      mon_ack_pipe <= ack_pipe;
      mon_ack_pld <= ack_has_pld;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic send_pkt(input logic [39:0] a, input bit crc, input bit nak, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pk_valid = 1; pk_data = 8'h40 + 8'(i); pk_last = (i == len - 1);
      pk_addr = a; pk_crc_ok = crc; pk_no_ack = nak;
      #1;
      while (!pk_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    pk_valid = 0; pk_last = 0;
  endtask

  task automatic pop_clear();
    @(negedge clk); rx_pop = 1; rx_dr_clr = 1;
    @(negedge clk); rx_pop = 0; rx_dr_clr = 0;
  endtask

  task automatic run_vec(input vec_t v, input int k);
    int bw, ba, bl;
    bw = mon_wr; ba = mon_ack; bl = mon_lastcnt;
    tx_pending = v.txp;
    send_pkt(v.addr, v.crc, v.nak, int'(v.len));
    repeat (4) @(negedge clk);
    chk($sformatf("R4 vec%0d byte count", k), mon_wr - bw, v.n);
    chk($sformatf("R8 vec%0d ack count", k), mon_ack - ba, v.ack);
    if (v.n != 0) begin
      chk($sformatf("R4 vec%0d first byte", k), mon_data[bw % 64], 8'h40);
      chk($sformatf("R4 vec%0d final byte", k), mon_data[(bw + v.n - 1) % 64], 8'h40 + v.n - 1);
      chk($sformatf("R4 vec%0d last flag", k), mon_lastcnt - bl, 1);
      chk($sformatf("R4 vec%0d write tag", k), mon_pipe, v.pipe);
      chk($sformatf("R6 vec%0d pipe field", k), rx_pipe_no, v.pipe);
      chk($sformatf("R5 vec%0d irq", k), irq, 1);
    end else begin
      chk($sformatf("R2 vec%0d irq stays low", k), irq, 0);
    end
    if (v.ack) begin
      chk($sformatf("R8 vec%0d ack pipe", k), mon_ack_pipe, v.pipe);
      chk($sformatf("R8 vec%0d ack payload", k), mon_ack_pld, v.txp);
    end
    pop_clear();
    #1;
    chk($sformatf("R6 vec%0d empty code", k), rx_pipe_no, 7);
    chk($sformatf("R5 vec%0d cleared", k), irq, 0);
    tx_pending = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int bw, ba;
    cfg_pipe_en  = 6'b110111;
    cfg_auto_ack = 6'b001111;
    cfg_addr = {A2, A4, A3, A2, A1, A0};
    cfg_width = {6'd6, 6'd5, 6'd2, 6'd3, 6'd8, 6'd4};
    repeat (4) @(negedge clk);
    #1;
    // reset state (R5 R6 R8 R1)
    chk("R5 reset irq", irq, 0);
    chk("R6 reset pipe field", rx_pipe_no, 7);
    chk("R8 reset ack_valid", ack_valid, 0);
    chk("R1 reset rx_active", rx_active, 0);
    @(negedge clk); rst_n = 1;

    // R1: packet during settling is dropped
    @(negedge clk); chip_en = 1; rx_mode = 1;
    bw = mon_wr;
    send_pkt(A0, 1, 0, 4);
    repeat (3) @(negedge clk);
    chk("R1 packet during settle writes", mon_wr - bw, 0);
    chk("R1 irq after settle drop", irq, 0);
    // R1: settle timing
    @(negedge clk); chip_en = 0;
    @(negedge clk); chip_en = 1;
    repeat (SETTLE - 1) @(posedge clk);
    #1 chk("R1 not yet active", rx_active, 0);
    @(posedge clk);
    #1 chk("R1 active after settle", rx_active, 1);

    // main table
    for (int k = 0; k < 10; k++) run_vec(VECS[k], k);

    // R7 + R6 ordering
    bw = mon_wr; ba = mon_ack;
    send_pkt(A0, 1, 0, 4); repeat (3) @(negedge clk);
    send_pkt(A4, 1, 0, 5);
    send_pkt(A1, 1, 1, 8);
    repeat (3) @(negedge clk);
    chk("R7 full flag", rx_full, 1);
    chk("R6 oldest is pipe 0", rx_pipe_no, 0);
    bw = mon_wr; ba = mon_ack;
    send_pkt(A0, 1, 0, 4); repeat (4) @(negedge clk);
    chk("R7 full drop writes", mon_wr - bw, 0);
    chk("R7 full drop ack", mon_ack - ba, 0);
    @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0; #1;
    chk("R6 second oldest", rx_pipe_no, 4);
    @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0; #1;
    chk("R6 third oldest", rx_pipe_no, 1);
    @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0; #1;
    chk("R6 drained", rx_pipe_no, 7);
    @(negedge clk); rx_pop = 1; @(negedge clk); rx_pop = 0;
    send_pkt(A4, 1, 0, 5); repeat (2) @(negedge clk);
    chk("R6 pop on empty ignored", rx_pipe_no, 4);
    chk("R7 not full", rx_full, 0);
    pop_clear();

    // R5 clear and store in same cycle
    @(negedge clk); rx_dr_clr = 1;
    send_pkt(A4, 1, 0, 5);
    rx_dr_clr = 0;
    #1 chk("R5 set beats clear", irq, 1);
    @(negedge clk); rx_dr_clr = 1; @(negedge clk); rx_dr_clr = 0; #1;
    chk("R5 lone clear", irq, 0);
    chk("R5 entry kept after clear", rx_pipe_no, 4);
    pop_clear();

    // R10 back-pressure
    bw = mon_wr;
    fifo_wr_ready = 0;
    fork
      send_pkt(A4, 1, 0, 5);
      begin
        repeat (4) @(negedge clk); #1;
        chk("R10 stall holds input", pk_ready, 0);
        chk("R10 stall write pending", fifo_wr_valid, 1);
        chk("R10 nothing written", mon_wr - bw, 0);
        @(negedge clk); fifo_wr_ready = 1;
      end
    join
    repeat (2) @(negedge clk);
    chk("R10 all bytes after stall", mon_wr - bw, 5);
    pop_clear();

    // R8 ack held, next packet blocked
    ba = mon_ack;
    ack_ready = 0; tx_pending = 1;
    send_pkt(A0, 1, 0, 4);
    tx_pending = 0;
    repeat (3) @(negedge clk);
    pk_valid = 1; pk_addr = A1; pk_crc_ok = 1; pk_data = 8'h40; pk_last = 1;
    #1;
    chk("R8 ack held", ack_valid, 1);
    chk("R8 ack pipe held", ack_pipe, 0);
    chk("R8 ack payload latched", ack_has_pld, 1);
    chk("R8 input blocked during ack", pk_ready, 0);
    @(negedge clk); pk_valid = 0; pk_last = 0; ack_ready = 1;
    repeat (2) @(negedge clk);
    chk("R8 ack taken once", mon_ack - ba, 1);
    pop_clear();

    // R2 zero width falls through to pipe 5
    @(negedge clk); cfg_width[2*WW +: WW] = '0;
    bw = mon_wr; ba = mon_ack;
    send_pkt(A2, 1, 0, 3); repeat (3) @(negedge clk);
    chk("R2 zero width skipped", mon_pipe, 5);
    chk("R2 fallback bytes", mon_wr - bw, 3);
    chk("R8 fallback no ack", mon_ack - ba, 0);
    pop_clear();
    cfg_width[2*WW +: WW] = 6'd3;

    // R9 standby keeps stored data
    send_pkt(A1, 1, 1, 8); repeat (2) @(negedge clk);
    chip_en = 0; #1;
    chk("R9 inactive at once", rx_active, 0);
    bw = mon_wr;
    send_pkt(A0, 1, 0, 4); repeat (3) @(negedge clk);
    chk("R9 standby drops packet", mon_wr - bw, 0);
    chk("R9 stored pipe visible", rx_pipe_no, 1);
    chk("R9 flag kept", irq, 1);
    pop_clear(); #1;
    chk("R9 pop in standby", rx_pipe_no, 7);

    finish_run();
  end
endmodule